// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters on an asynchronous serial line. It has a one-character holding register in front of a frame shift register. Software hands over a character with a single-cycle write strobe. If the line is idle, the character goes into the shift register in the same clock edge and its start bit appears on the next cycle. If a frame is already on the line, the character waits in the holding register. It moves into the shift register at the edge where the current stop bit ends. The next start bit therefore follows the stop bit with no idle cycles between frames.

Two flags report progress. The empty flag tells software that the holding register can take another character. The complete flag tells software that the line has gone idle with nothing pending. Each flag has its own interrupt request, gated by an enable input. Bit timing comes from a 12-bit divisor: each bit lasts divisor + 1 clock cycles. Frames carry 8 data bits, or 9 data bits where the ninth is supplied on a separate input.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, `tx` is 1, `dre` is 1, `tc` is 0, and both interrupt requests are 0.
- R2: Each frame has the following bits, in order, and each bit lasts `divisor`+1 clock cycles:
  - one start bit at 0;
  - the data bits, least significant bit first;
  - one stop bit at 1.

  The line stays at 1 whenever no frame is being sent.
- R3: The frame length is taken from `nine_bit` when the character is loaded into the shift register.
  - When `nine_bit` is 0, the frame has 8 data bits (10 bits in all), and `wr_bit8` has no effect.
  - When `nine_bit` is 1, the frame has 9 data bits (11 bits in all), and the value of `wr_bit8` is sent directly after data bit 7.
- R4: A write that arrives while the line is idle, or in the very cycle the last stop bit ends with nothing pending, goes straight to the shift register. `tx` is 0 on the next cycle and `dre` stays 1.
- R5: A write that arrives while a frame is in progress drives `dre` to 0. The character is held until the stop bit of the current frame has lasted its full length. On the next cycle, `dre` returns to 1 and `tx` carries the start bit of the held character, with no idle cycle in between.
- R6: A write while `dre` is 0 replaces the pending character without any error indication. Only the last character written is sent.
- R7: `tc` rises when a stop bit ends and no character is pending. A write or a `tc_clear` pulse clears `tc` on the next cycle, and a clear takes priority over a set in the same cycle.
- R8: `irq_dre` equals `dre` AND `dre_ie`. `irq_tc` equals `tc` AND `tc_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 12 | Bit period minus one, in clock cycles |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Character data bits 7..0 |
| wr_bit8 | input | 1 | Ninth data bit, used when `nine_bit` is 1 |
| tc_clear | input | 1 | Clears the complete flag |
| dre_ie | input | 1 | Enable for the empty interrupt request |
| tc_ie | input | 1 | Enable for the complete interrupt request |
| tx | output | 1 | Serial output, idles high |
| dre | output | 1 | Holding register empty flag |
| tc | output | 1 | Transmission complete flag |
| irq_dre | output | 1 | Empty interrupt request |
| irq_tc | output | 1 | Complete interrupt request |

## Verification
Most internal faults become visible at `tx` within one bit period. Examples are a bit counter that is off by one, a shift register that shifts in the wrong direction, or a character lost during the hand-over. Each of these produces a wrong level at the middle of some bit, or a start bit that comes one period early or late. Faults in the flag logic show up at `dre` and `tc` in the exact cycle where the bench expects them to change. Examples are a pending character left unmarked, or a complete flag that rises while a character is pending. The bench samples these flags on both sides of each transfer edge, so a fault that shifts a flag by a single cycle is also caught.

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             nine_bit,
  input  logic             wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic             wr_bit8,
  input  logic             tc_clear,
  input  logic             dre_ie,
  input  logic             tc_ie,
  output logic             tx,
  output logic             dre,
  output logic             tc,
  output logic             irq_dre,
  output logic             irq_tc
);
  localparam int FW = DATA_W + 3;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0]     sh;
  logic [LW-1:0]     left;
  logic [DIV_W-1:0]  cnt;
  logic [DATA_W-1:0] hold;
  logic              hold_b8;
  logic              busy;

  function automatic logic [FW-1:0] frame(input logic [DATA_W-1:0] d, input logic b8, input logic nb);
    frame = {1'b1, nb ? b8 : 1'b1, d, 1'b0};
  endfunction

  wire [LW-1:0] len       = nine_bit ? LW'(FW) : LW'(FW - 1);
  wire          bit_end   = busy && (cnt == '0);
  wire          stop_done = bit_end && (left == LW'(1));
  wire          load_wr   = wr_en && (!busy || (stop_done && dre));
  wire          load_hold = stop_done && !dre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load_hold) begin
      sh   <= frame(hold, hold_b8, nine_bit);
      left <= len;
      cnt  <= divisor;
      busy <= 1'b1;
    end else if (load_wr) begin
      sh   <= frame(wr_data, wr_bit8, nine_bit);
      left <= len;
      cnt  <= divisor;
      busy <= 1'b1;
    end else if (stop_done) begin
      busy <= 1'b0;
    end else if (bit_end) begin
      sh   <= {1'b1, sh[FW-1:1]};
      left <= left - LW'(1);
      cnt  <= divisor;
    end else if (busy) begin
      cnt  <= cnt - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      hold_b8 <= 1'b0;
      dre     <= 1'b1;
    end else if (wr_en && !load_wr) begin
      hold    <= wr_data;
      hold_b8 <= wr_bit8;
      dre     <= 1'b0;
    end else if (load_hold) begin
      dre     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tc <= 1'b0;
    else if (wr_en || tc_clear) tc <= 1'b0;
    else if (stop_done && dre)  tc <= 1'b1;
  end

  assign tx      = busy ? sh[0] : 1'b1;
  assign irq_dre = dre & dre_ie;
  assign irq_tc  = tc & tc_ie;
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tc_clear,
  input logic tx,
  input logic dre,
  input logic tc,
  input logic busy,
  input logic stop_done
);
  p_tc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) tc |-> tx);
  p_idle_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (!tx && dre));
  p_busy_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !(stop_done && dre)) |=> !dre);
  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(dre) |-> !tx);
  p_tc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || tc_clear) |=> !tc);
  p_tc_empty_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(tc) |-> dre);
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tc_clear(tc_clear), .tx(tx),
  .dre(dre), .tc(tc), .busy(busy), .stop_done(stop_done)
);

// File: tb/tb_uart_dbuf_tx.sv
module tb_uart_dbuf_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] divisor = 12'd3;
  logic nine_bit = 1'b0, wr_en = 1'b0, wr_bit8 = 1'b0, tc_clear = 1'b0;
  logic dre_ie = 1'b0, tc_ie = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx, dre, tc, irq_dre, irq_tc;
  int checks = 0, fails = 0, j = 0, cyc = 0;

  uart_dbuf_tx dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .nine_bit(nine_bit),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bit8(wr_bit8), .tc_clear(tc_clear),
    .dre_ie(dre_ie), .tc_ie(tc_ie), .tx(tx), .dre(dre), .tc(tc),
    .irq_dre(irq_dre), .irq_tc(irq_tc)
  );

  always #4 clk = ~clk;

  // {divisor[21:10], nine_bit[9], bit8[8], data[7:0]}
  localparam logic [21:0] VEC [6] = '{
    {12'd3, 1'b0, 1'b0, 8'hA5},
    {12'd0, 1'b0, 1'b0, 8'h3C},
    {12'd5, 1'b1, 1'b1, 8'h81},
    {12'd2, 1'b1, 1'b0, 8'hFF},
    {12'd1, 1'b0, 1'b1, 8'h00},
    {12'd7, 1'b1, 1'b1, 8'h5A}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at j=%0d: actual %b expected %b", req, j, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    j++;
  endtask

  task automatic goto(input int t);
    while (j < t) step();
  endtask

  task automatic wr(input logic [7:0] d, input logic b8);
    wr_data = d;
    wr_bit8 = b8;
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  function automatic int flen(input logic nb);
    return nb ? 11 : 10;
  endfunction

  task automatic run_frame(input string req, input logic [7:0] d, input logic b8,
                           input logic nb, input int dv, input int base);
    for (int k = 0; k < flen(nb); k++) begin
      logic e;
      if (k == 0) e = 1'b0;
      else if (k <= 8) e = d[k-1];
      else if (k == 9) e = nb ? b8 : 1'b1;
      else e = 1'b1;
      goto(base + k * (dv + 1) + dv / 2);
      chk(req, tx, e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx", tx, 1'b1);
    chk("R1 dre", dre, 1'b1);
    chk("R1 tc", tc, 1'b0);
    chk("R1 irq_dre", irq_dre, 1'b0);
    chk("R1 irq_tc", irq_tc, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      int dv;
      int n;
      dv = int'(VEC[v][21:10]);
      divisor = VEC[v][21:10];
      nine_bit = VEC[v][9];
      n = flen(VEC[v][9]);
      wr(VEC[v][7:0], VEC[v][8]);
      j = 0;
      chk("R4 start at once", tx, 1'b0);
      chk("R4 dre stays 1", dre, 1'b1);
      chk("R7 write clears tc", tc, 1'b0);
      run_frame(VEC[v][9] ? "R3 nine-bit frame" : "R2 frame", VEC[v][7:0], VEC[v][8], VEC[v][9], dv, 0);
      goto(n * (dv + 1) - 1);
      chk("R7 tc before stop end", tc, 1'b0);
      goto(n * (dv + 1));
      chk("R7 tc at stop end", tc, 1'b1);
      chk("R2 idle high", tx, 1'b1);
    end

    divisor = 12'd2;
    nine_bit = 1'b0;
    wr(8'h96, 1'b0);
    j = 0;
    wr(8'h4B, 1'b0);
    chk("R5 dre low while pending", dre, 1'b0);
    run_frame("R5 first frame", 8'h96, 1'b0, 1'b0, 2, 0);
    goto(29);
    chk("R5 stop bit still out", tx, 1'b1);
    chk("R5 dre low until stop end", dre, 1'b0);
    goto(30);
    chk("R5 start with no gap", tx, 1'b0);
    chk("R5 dre set on transfer", dre, 1'b1);
    chk("R7 tc not set while pending", tc, 1'b0);
    run_frame("R5 second frame", 8'h4B, 1'b0, 1'b0, 2, 30);
    goto(59);
    chk("R7 tc low before last stop end", tc, 1'b0);
    goto(60);
    chk("R7 tc after last frame", tc, 1'b1);

    wr(8'h11, 1'b0);
    j = 0;
    wr(8'h22, 1'b0);
    wr(8'hC3, 1'b0);
    chk("R6 dre low", dre, 1'b0);
    run_frame("R6 first frame", 8'h11, 1'b0, 1'b0, 2, 0);
    run_frame("R6 overwritten char sent", 8'hC3, 1'b0, 1'b0, 2, 30);
    goto(60);
    chk("R6 tc after", tc, 1'b1);

    tc_clear = 1'b1;
    step();
    tc_clear = 1'b0;
    chk("R7 tc_clear", tc, 1'b0);
    chk("R2 idle after clear", tx, 1'b1);

    divisor = 12'd1;
    wr(8'hE7, 1'b0);
    j = 0;
    goto(19);
    wr(8'h18, 1'b0);
    chk("R4 write at stop end starts at once", tx, 1'b0);
    chk("R4 write at stop end dre", dre, 1'b1);
    chk("R4 write at stop end tc", tc, 1'b0);
    run_frame("R4 boundary frame", 8'h18, 1'b0, 1'b0, 1, 20);
    goto(40);
    chk("R7 tc after boundary frame", tc, 1'b1);

    dre_ie = 1'b1;
    tc_ie = 1'b1;
    @(negedge clk);
    chk("R8 irq_dre", irq_dre, 1'b1);
    chk("R8 irq_tc", irq_tc, 1'b1);
    wr(8'h01, 1'b0);
    chk("R8 irq_tc off after write", irq_tc, 1'b0);
    wr(8'h02, 1'b0);
    chk("R8 irq_dre off while pending", irq_dre, 1'b0);
    tc_ie = 1'b0;
    dre_ie = 1'b0;
    @(negedge clk);
    chk("R8 irq_dre gated", irq_dre, 1'b0);
    repeat (60) @(negedge clk);
    chk("R8 irq_tc gated", irq_tc, 1'b0);
    chk("R7 tc set", tc, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule